// File: doc/BRIEF.md
# Dual-Channel Encoded-Ratio Clock Postscaler

This block derives two slower clock enables from one fast clock. One channel runs a DSP domain and counts every fast-clock cycle. The other runs an accelerator domain and counts the cycles of one of two source qualifiers, chosen by a select input. Each channel takes a 3-bit ratio code that maps onto an irregular set of divide ratios, and has its own hold input that keeps its divider in reset.

Each channel gives two outputs. The first is a one-cycle tick that closes every group of N counted cycles. The second is a registered divided-clock level for logic that needs a duty cycle rather than an enable.

A new ratio code is picked up when a channel leaves hold. While the channel runs, a new code takes effect only at the end of the period in progress, so no period is ever cut short.

Top module: `dual_clk_postscaler`

## Requirements
- R1: The ratio code maps to the divide ratio N as follows: 0→1, 1→2, 2→3, 3→4, 4→6, 5→8, 6→12, 7→12.
- R2: While a channel runs, its tick output is high for one cycle on every N-th counted cycle and low on all other cycles.
- R3: The divided-clock output is high during the last H counted positions of each period and low otherwise. H is N/2 for even N, and 1 for N=3. For N=1 the output stays high while the channel runs.
- R4: While a channel's hold input is 1, its tick and divided-clock outputs are 0, and any changes on its ratio code have no effect.
- R5: When hold is released, the channel loads the ratio code present at the release edge and starts counting from zero. Its first tick falls on the N-th counted cycle after release.
- R6: A ratio code changed while the channel runs is adopted only at the next terminal count. The period in progress completes at the old ratio.
- R7: The two channels are independent. Holding or recoding one does not change the other's outputs.
- R8: The accelerator channel counts only the cycles in which its selected source qualifier is 1. Select 0 chooses source A and select 1 chooses source B. The DSP channel counts every cycle.
- R9: The synchronous active-low reset clears both channels to the held state (outputs 0). Afterwards each channel behaves as on a hold release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dsp_hold | input | 1 | Keeps the DSP divider in reset while 1 |
| dsp_code | input | 3 | DSP ratio code |
| acc_hold | input | 1 | Keeps the accelerator divider in reset while 1 |
| acc_code | input | 3 | Accelerator ratio code |
| acc_src_sel | input | 1 | Accelerator source select (0 = A, 1 = B) |
| acc_src_a | input | 1 | Source A qualifier, one count per cycle at 1 |
| acc_src_b | input | 1 | Source B qualifier, one count per cycle at 1 |
| dsp_tick | output | 1 | DSP one-cycle period tick |
| dsp_clk | output | 1 | DSP registered divided-clock level |
| acc_tick | output | 1 | Accelerator one-cycle period tick |
| acc_clk | output | 1 | Accelerator registered divided-clock level |

## Verification
The assertions assume the following about the inputs:
- The source qualifiers are synchronous to the fast clock.
- The hold, code and select inputs settle well before a clock edge.
- Reset is asserted from time zero.

The assertions also take for granted that a new ratio is loaded only at a release or at a terminal count. Every other internal change is treated as a fault.

The stimulus keeps within these assumptions. It changes every input on the falling clock edge and holds reset low from the start. It changes codes mid-run only at chosen counts, which exercises the deferred-latch rule without violating the settling assumption.

// File: rtl/pscl_pkg.sv
`timescale 1ns/1ps
// Package: shared sizes and helpers for the encoded-ratio postscaler.
// Assumes the largest encodable ratio is MAX_RATIO and codes are CODE_W bits.
package pscl_pkg;
    localparam int CODE_W    = 3;
    localparam int MAX_RATIO = 12;
    localparam int RATIO_W   = $clog2(MAX_RATIO + 1);
    localparam int NUM_CH    = 2;

    // Number of high positions at the end of a period of length n.
    function automatic logic [RATIO_W-1:0] high_len(input logic [RATIO_W-1:0] n);
        if (n == RATIO_W'(1) || n == RATIO_W'(3))
            return RATIO_W'(1);
        return n >> 1;
    endfunction
endpackage

// File: rtl/pscl_ratio_decode.sv
`timescale 1ns/1ps
// Module: maps a ratio code to its divide ratio (irregular, not a power of two).
// Assumes CODE_W = 3; any code beyond the listed ones saturates at the top ratio.
module pscl_ratio_decode
    import pscl_pkg::*;
(
    input  logic [CODE_W-1:0]  code,
    output logic [RATIO_W-1:0] ratio
);
    // Combinational code-to-ratio lookup.
    always_comb begin
        case (code)
            CODE_W'(0): ratio = RATIO_W'(1);
            CODE_W'(1): ratio = RATIO_W'(2);
            CODE_W'(2): ratio = RATIO_W'(3);
            CODE_W'(3): ratio = RATIO_W'(4);
            CODE_W'(4): ratio = RATIO_W'(6);
            CODE_W'(5): ratio = RATIO_W'(8);
            default:    ratio = RATIO_W'(MAX_RATIO);
        endcase
    end
endmodule

// File: rtl/pscl_divider.sv
`timescale 1ns/1ps
// Module: one postscaler channel. Counts qualified cycles (step) modulo the
// decoded ratio, emits a one-cycle tick on the terminal count and a registered
// divided-clock level. Hold clears the counter and masks the code; a new ratio
// is taken at hold release or at a terminal count only.
// Assumes step, hold and code are synchronous to clk.
module pscl_divider
    import pscl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              step,
    input  logic [CODE_W-1:0] code,
    output logic              tick,
    output logic              div_clk
);
    logic [RATIO_W-1:0] cnt_q, cnt_d;
    logic [RATIO_W-1:0] ratio_q, ratio_d;
    logic [RATIO_W-1:0] code_ratio;
    logic               run_q, run_d;
    logic               div_q, div_d;
    logic               at_end;

    pscl_ratio_decode u_dec (
        .code  (code),
        .ratio (code_ratio)
    );

    // Terminal count: the step that closes the current period.
    assign at_end = run_q && step && (cnt_q == ratio_q - RATIO_W'(1));

    // Next-state logic for counter, latched ratio, run flag and clock level.
    always_comb begin
        cnt_d   = cnt_q;
        ratio_d = ratio_q;
        run_d   = run_q;
        if (hold) begin
            cnt_d = '0;
            run_d = 1'b0;
        end else if (!run_q) begin
            run_d   = 1'b1;
            ratio_d = code_ratio;
            cnt_d   = '0;
        end else if (step) begin
            if (at_end) begin
                cnt_d   = '0;
                ratio_d = code_ratio;
            end else begin
                cnt_d = cnt_q + RATIO_W'(1);
            end
        end
        div_d = run_d && (cnt_d >= ratio_d - high_len(ratio_d));
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ratio_q <= RATIO_W'(1);
            run_q   <= 1'b0;
            div_q   <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            ratio_q <= ratio_d;
            run_q   <= run_d;
            div_q   <= div_d;
        end
    end

    assign tick    = at_end;
    assign div_clk = div_q;

    // R1: the latched ratio is always one of the encodable ratios.
    assert_legal_ratio_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_q inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd8, 4'd12});

    // R2: the count never reaches the ratio.
    assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < ratio_q);

    // R4: one cycle after hold, both outputs are quiet.
    assert_hold_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hold) |-> (!tick && !div_clk));

    // R5: a channel that starts running starts from count zero.
    assert_start_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_q) |-> (cnt_q == '0));

    // R6: mid-period the latched ratio does not move.
    assert_latch_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && run_q && !at_end) |=> $stable(ratio_q));

    // R8: a tick requires a qualified cycle.
    assert_tick_needs_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> step);
endmodule

// File: rtl/dual_clk_postscaler.sv
`timescale 1ns/1ps
// Module: top of the dual-channel postscaler. Channel 0 (DSP) counts every
// fast-clock cycle; channel 1 (accelerator) counts cycles of the source
// qualifier chosen by acc_src_sel. Both channels use the same divider.
// Assumes all inputs are synchronous to clk.
module dual_clk_postscaler
    import pscl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dsp_hold,
    input  logic [CODE_W-1:0] dsp_code,
    input  logic              acc_hold,
    input  logic [CODE_W-1:0] acc_code,
    input  logic              acc_src_sel,
    input  logic              acc_src_a,
    input  logic              acc_src_b,
    output logic              dsp_tick,
    output logic              dsp_clk,
    output logic              acc_tick,
    output logic              acc_clk
);
    localparam int CH_DSP = 0;
    localparam int CH_ACC = 1;

    logic [NUM_CH-1:0]              hold_v;
    logic [NUM_CH-1:0]              step_v;
    logic [NUM_CH-1:0]              tick_v;
    logic [NUM_CH-1:0]              div_v;
    logic [NUM_CH-1:0][CODE_W-1:0]  code_v;
    logic                           acc_step;

    // Source select for the accelerator channel.
    assign acc_step = acc_src_sel ? acc_src_b : acc_src_a;

    // Gather per-channel controls into vectors.
    always_comb begin
        hold_v[CH_DSP] = dsp_hold;
        hold_v[CH_ACC] = acc_hold;
        code_v[CH_DSP] = dsp_code;
        code_v[CH_ACC] = acc_code;
        step_v[CH_DSP] = 1'b1;
        step_v[CH_ACC] = acc_step;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pscl_divider u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .hold    (hold_v[g]),
            .step    (step_v[g]),
            .code    (code_v[g]),
            .tick    (tick_v[g]),
            .div_clk (div_v[g])
        );
    end

    assign dsp_tick = tick_v[CH_DSP];
    assign dsp_clk  = div_v[CH_DSP];
    assign acc_tick = tick_v[CH_ACC];
    assign acc_clk  = div_v[CH_ACC];

    // R8: an accelerator tick only comes with the chosen source active.
    assert_acc_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_tick |-> (acc_src_sel ? acc_src_b : acc_src_a));

    // R9: one cycle out of reset, every output is still low.
    assert_reset_quiet_R9: assert property (@(posedge clk)
        $rose(rst_n) |-> !(dsp_tick || dsp_clk || acc_tick || acc_clk));
endmodule

// File: tb/sim_dual_clk_postscaler.sv
`timescale 1ns/1ps
module sim_dual_clk_postscaler;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       dsp_hold, acc_hold, acc_src_sel, acc_src_a, acc_src_b;
    logic [2:0] dsp_code, acc_code;
    logic       dsp_tick, dsp_clk, acc_tick, acc_clk;
    int         n_vec = 0;
    int         n_bad = 0;
    logic [15:0] lf = 16'hACE1;

    always #2.5 clk = ~clk;

    dual_clk_postscaler u0 (
        .clk(clk), .rst_n(rst_n),
        .dsp_hold(dsp_hold), .dsp_code(dsp_code),
        .acc_hold(acc_hold), .acc_code(acc_code),
        .acc_src_sel(acc_src_sel), .acc_src_a(acc_src_a), .acc_src_b(acc_src_b),
        .dsp_tick(dsp_tick), .dsp_clk(dsp_clk),
        .acc_tick(acc_tick), .acc_clk(acc_clk)
    );

    function automatic int ratio_of(input int code);
        if (code < 4) return code + 1;
        if (code == 4) return 6;
        if (code == 5) return 8;
        return 12;
    endfunction

    function automatic int high_of(input int n);
        if (n == 1 || n == 3) return 1;
        return n / 2;
    endfunction

    task automatic check(input string req, input logic act, input logic exp, input int ctx);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s ctx=%0d actual=%0b expected=%0b", req, ctx, act, exp);
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    task automatic lfsr_step();
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    // DSP sweep of one code: release, then check tick and level over 3 periods.
    task automatic dsp_sweep(input int code);
        int n, h;
        n = ratio_of(code);
        h = high_of(n);
        @(negedge clk); dsp_hold = 1'b1; dsp_code = code[2:0];
        @(negedge clk); dsp_hold = 1'b0;
        for (int i = 1; i <= 3 * n + 2; i++) begin
            @(negedge clk); #1;
            check("R1 R2 R5 dsp tick", dsp_tick, (i % n) == 0, code * 100 + i);
            check("R3 dsp level", dsp_clk, ((i - 1) % n) >= n - h, code * 100 + i);
        end
    endtask

    // Accelerator sweep of one code with pseudo-random qualifiers on both sources.
    task automatic acc_sweep(input int code, input logic sel);
        int n, h, s;
        logic stp;
        n = ratio_of(code);
        h = high_of(n);
        s = 0;
        @(negedge clk); acc_hold = 1'b1; acc_code = code[2:0]; acc_src_sel = sel;
        @(negedge clk); acc_hold = 1'b0;
        for (int i = 1; i <= 4 * n + 6; i++) begin
            @(negedge clk);
            lfsr_step();
            acc_src_a = lf[0] | lf[3];
            acc_src_b = lf[5];
            stp = sel ? acc_src_b : acc_src_a;
            #1;
            check("R8 acc tick", acc_tick, stp && ((s % n) == n - 1), code * 100 + i);
            check("R3 acc level", acc_clk, (s % n) >= n - h, code * 100 + i);
            if (stp) s++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        rst_n = 1'b0; dsp_hold = 1'b0; acc_hold = 1'b0;
        dsp_code = 3'd1; acc_code = 3'd0; acc_src_sel = 1'b0;
        acc_src_a = 1'b1; acc_src_b = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check("R9 reset dsp tick", dsp_tick, 1'b0, 0);
        check("R9 reset dsp level", dsp_clk, 1'b0, 0);
        check("R9 reset acc tick", acc_tick, 1'b0, 0);
        check("R9 reset acc level", acc_clk, 1'b0, 0);
        // Leave reset with hold low: both behave as on a release.
        @(negedge clk); rst_n = 1'b1;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk); #1;
            check("R9 dsp after reset", dsp_tick, (i % 2) == 0, i);
            check("R9 acc after reset", acc_tick, 1'b1, i);
        end

        // R4: under hold, code changes do nothing; outputs stay low.
        @(negedge clk); dsp_hold = 1'b1; acc_hold = 1'b1;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk); dsp_code = c[2:0]; acc_code = 3'(7 - c); acc_src_a = 1'b1; #1;
            check("R4 held dsp tick", dsp_tick, 1'b0, c);
            check("R4 held dsp level", dsp_clk, 1'b0, c);
            check("R4 held acc tick", acc_tick, 1'b0, c);
            check("R4 held acc level", acc_clk, 1'b0, c);
        end

        // R1 R2 R3 R5: full code sweep on the DSP channel.
        for (int c = 0; c < 8; c++) dsp_sweep(c);

        // R8: code sweep on the accelerator channel with each source selected.
        for (int c = 0; c < 8; c++) acc_sweep(c, 1'b0);
        for (int c = 0; c < 8; c++) acc_sweep(c, 1'b1);

        // R6: ratio 4 running, code to ratio 8 at count 1; old period completes.
        @(negedge clk); dsp_hold = 1'b1; dsp_code = 3'd3;
        @(negedge clk); dsp_hold = 1'b0;
        for (int i = 1; i <= 30; i++) begin
            @(negedge clk); #1;
            if (i <= 4) begin
                check("R6 old period tick", dsp_tick, i == 4, i);
                check("R6 old period level", dsp_clk, (i - 1) >= 2, i);
            end else begin
                check("R6 new period tick", dsp_tick, ((i - 5) % 8) == 7, i);
                check("R6 new period level", dsp_clk, ((i - 5) % 8) >= 4, i);
            end
            if (i == 2) dsp_code = 3'd5;
        end

        // R7: DSP at ratio 3 keeps its rhythm while the accelerator is held and recoded.
        @(negedge clk); dsp_hold = 1'b1; dsp_code = 3'd2; acc_hold = 1'b1;
        acc_src_sel = 1'b0; acc_src_a = 1'b1; acc_code = 3'd5;
        @(negedge clk); dsp_hold = 1'b0; acc_hold = 1'b0;
        for (int i = 1; i <= 40; i++) begin
            @(negedge clk);
            if (i == 10) acc_hold = 1'b1;
            if (i == 13) acc_code = 3'd0;
            if (i == 20) acc_hold = 1'b0;
            #1;
            check("R7 dsp unaffected", dsp_tick, (i % 3) == 0, i);
            check("R7 dsp level unaffected", dsp_clk, ((i - 1) % 3) >= 2, i);
            if (i <= 9) check("R7 acc ratio 8", acc_tick, i == 8, i);
        end

        // R9: reset mid-run silences both channels on the next cycle.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); #1;
        check("R9 mid-run reset dsp", dsp_tick | dsp_clk, 1'b0, 0);
        check("R9 mid-run reset acc", acc_tick | acc_clk, 1'b0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        summary();
    end
endmodule